// File: doc/BRIEF.md
# Banked Memory Address Translator

This block sits on the address path of a 16-bit CPU and does two jobs. It holds an 8-bit placement register whose two nibbles each choose a 4 KiB-aligned base: the lower nibble places the block of on-chip I/O registers and the upper nibble places the on-chip RAM. It also holds an 8-bit page register and turns any CPU address that lands inside a fixed bank window into a wider physical address. The page selects which slice of physical memory the window shows.

The window limits, the shift applied to the page number and a constant physical offset are elaboration-time parameters. Addresses outside the window pass through unchanged, zero-extended to the output width. Both registers are written through simple write-enable ports and take their new value on the next rising clock edge. The translation is combinational and uses the page value held at that moment. Two status outputs report whether the current address falls in the bank window and whether it falls in the 64-byte I/O register block.

Top module: `bank_xlate`

## Requirements
- R1: After synchronous reset the placement register reads 0x01 and the page register reads 0. So io_base is 0x1000, ram_base is 0x0000, and a window address maps with page 0.
- R2: io_base equals placement bits [3:0] shifted left by 12, with the low 12 bits zero.
- R3: ram_base equals placement bits [7:4] shifted left by 12, with the low 12 bits zero.
- R4: A register write takes effect on the first rising edge where its enable is high and reset is released. While its enable stays low the register keeps its value.
- R5: win_hit is 1 exactly when WIN_START <= cpu_addr < WIN_END. The start is included and the end is excluded.
- R6: On a window hit, phys_addr = (cpu_addr - WIN_START) + (page << BANK_SHIFT) + VIRT_BASE, computed modulo 2^OUT_W.
- R7: On a window miss, phys_addr equals cpu_addr zero-extended to OUT_W bits.
- R8: io_hit is 1 exactly when io_base <= cpu_addr < io_base + IO_SPAN, where IO_SPAN defaults to 64. The comparison does not wrap past 0xFFFF.
- R9: A page write in the same cycle as a window access does not affect that access. The access is translated with the old page, and the new page applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address to translate |
| place_we | input | 1 | Placement register write enable |
| place_wdata | input | 8 | Placement register write data |
| page_we | input | 1 | Page register write enable |
| page_wdata | input | 8 | Page register write data |
| phys_addr | output | OUT_W (24) | Translated physical address |
| win_hit | output | 1 | Address lies in the bank window |
| io_hit | output | 1 | Address lies in the I/O register block |
| io_base | output | 16 | Current I/O block base |
| ram_base | output | 16 | Current RAM base |

## Verification
A page write and a translation through the window can occur in the same cycle. The same holds for a placement write and an I/O-range lookup. The bench provokes the page case as follows: it presents a window address together with a page write, and samples phys_addr before the edge, where it must show the old page. It samples again after the edge, where the new page must appear. The placement case is judged the same way: io_hit is compared against the old base before the edge and against the new base after it.

// File: rtl/bank_xlate_pkg.sv
// Package: shared widths and helpers for the banked address translator.
// Assumes a 16-bit CPU address space split into 4 KiB placement slots.
package bank_xlate_pkg;
    localparam int CPU_AW     = 16;
    localparam int REG_W      = 8;
    localparam int SLOT_SHIFT = 12;

    typedef logic [CPU_AW-1:0] cpu_addr_t;
    typedef logic [REG_W-1:0]  reg8_t;

    // Place a 4-bit slot number at the top of a CPU address.
    function automatic cpu_addr_t slot_to_base(input logic [3:0] slot);
        return cpu_addr_t'(slot) << SLOT_SHIFT;
    endfunction
endpackage

// File: rtl/bank_cfg_regs.sv
// Module: bank_cfg_regs
// Holds the placement register and the page register.
// Assumes: synchronous active-low reset; writes land on the next rising edge.
module bank_cfg_regs
    import bank_xlate_pkg::*;
#(
    parameter logic [7:0] PLACE_RESET = 8'h01,
    parameter logic [7:0] PAGE_RESET  = 8'h00
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  place_we,
    input  reg8_t place_wdata,
    input  logic  page_we,
    input  reg8_t page_wdata,
    output reg8_t place_q,
    output reg8_t page_q
);
    // Placement register update.
    always_ff @(posedge clk) begin
        if (!rst_n)        place_q <= PLACE_RESET;
        else if (place_we) place_q <= place_wdata;
    end

    // Page register update.
    always_ff @(posedge clk) begin
        if (!rst_n)       page_q <= PAGE_RESET;
        else if (page_we) page_q <= page_wdata;
    end

    assert_place_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        place_we |=> (place_q == $past(place_wdata)));
    assert_place_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !place_we |=> $stable(place_q));
    assert_page_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        page_we |=> (page_q == $past(page_wdata)));
    assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !page_we |=> $stable(page_q));
endmodule

// File: rtl/bank_window_map.sv
// Module: bank_window_map
// Translates CPU addresses inside [WIN_START, WIN_END) to a wider physical
// address using the page; other addresses pass through zero-extended.
// Assumes: parameters are static; an empty window never hits.
module bank_window_map
    import bank_xlate_pkg::*;
#(
    parameter int                OUT_W      = 24,
    parameter logic [15:0]       WIN_START  = 16'h8000,
    parameter logic [15:0]       WIN_END    = 16'hC000,
    parameter int                BANK_SHIFT = 14,
    parameter logic [OUT_W-1:0]  VIRT_BASE  = 24'h010000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cpu_addr_t        cpu_addr,
    input  reg8_t            page,
    output logic [OUT_W-1:0] phys_addr,
    output logic             win_hit
);
    localparam bit WIN_EMPTY = (WIN_END <= WIN_START);

    logic             in_win;
    cpu_addr_t        win_off;
    logic [OUT_W-1:0] page_part;

    // Window membership: a parameter picks an empty or a live comparator.
    generate
        if (WIN_EMPTY) begin : g_empty
            assign in_win = 1'b0;
        end else begin : g_live
            assign in_win = (cpu_addr >= WIN_START) && (cpu_addr < WIN_END);
        end
    endgenerate

    // Offset inside the window and the page contribution.
    always_comb begin
        win_off   = cpu_addr - WIN_START;
        page_part = OUT_W'(page) << BANK_SHIFT;
    end

    // Output select: translated address on hit, zero-extended input on miss.
    always_comb begin
        if (in_win) phys_addr = OUT_W'(win_off) + page_part + VIRT_BASE;
        else        phys_addr = OUT_W'(cpu_addr);
    end

    assign win_hit = in_win;

    assert_miss_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> (phys_addr == OUT_W'(cpu_addr)));
    assert_hit_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (cpu_addr >= WIN_START));
endmodule

// File: rtl/bank_io_decode.sv
// Module: bank_io_decode
// Flags addresses inside the I/O register block [base, base+IO_SPAN).
// Assumes: the comparison is done in 17 bits so the span never wraps.
module bank_io_decode
    import bank_xlate_pkg::*;
#(
    parameter int IO_SPAN = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  cpu_addr_t cpu_addr,
    input  cpu_addr_t io_base,
    output logic      io_hit
);
    localparam int EXT_W = CPU_AW + 1;

    logic [EXT_W-1:0] lo_ext, hi_ext, a_ext;

    // Range compare in widened arithmetic.
    always_comb begin
        a_ext  = EXT_W'(cpu_addr);
        lo_ext = EXT_W'(io_base);
        hi_ext = lo_ext + EXT_W'(IO_SPAN);
        io_hit = (a_ext >= lo_ext) && (a_ext < hi_ext);
    end

    assert_io_lower_R8: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> (cpu_addr >= io_base));
endmodule

// File: rtl/bank_xlate.sv
// Module: bank_xlate (top)
// Address translator: placement register gives I/O and RAM bases, page
// register drives bank-window translation.
// Assumes: synchronous active-low reset; translation is combinational.
module bank_xlate
    import bank_xlate_pkg::*;
#(
    parameter int                OUT_W       = 24,
    parameter logic [15:0]       WIN_START   = 16'h8000,
    parameter logic [15:0]       WIN_END     = 16'hC000,
    parameter int                BANK_SHIFT  = 14,
    parameter logic [OUT_W-1:0]  VIRT_BASE   = 24'h010000,
    parameter int                IO_SPAN     = 64,
    parameter logic [7:0]        PLACE_RESET = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic              place_we,
    input  logic [7:0]        place_wdata,
    input  logic              page_we,
    input  logic [7:0]        page_wdata,
    output logic [OUT_W-1:0]  phys_addr,
    output logic              win_hit,
    output logic              io_hit,
    output logic [15:0]       io_base,
    output logic [15:0]       ram_base
);
    reg8_t place_q, page_q;

    bank_cfg_regs #(.PLACE_RESET(PLACE_RESET), .PAGE_RESET(8'h00)) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .place_we(place_we), .place_wdata(place_wdata),
        .page_we(page_we), .page_wdata(page_wdata),
        .place_q(place_q), .page_q(page_q)
    );

    // Base derivation from the two placement nibbles.
    always_comb begin
        io_base  = slot_to_base(place_q[3:0]);
        ram_base = slot_to_base(place_q[7:4]);
    end

    bank_window_map #(
        .OUT_W(OUT_W), .WIN_START(WIN_START), .WIN_END(WIN_END),
        .BANK_SHIFT(BANK_SHIFT), .VIRT_BASE(VIRT_BASE)
    ) map_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .page(page_q),
        .phys_addr(phys_addr), .win_hit(win_hit)
    );

    bank_io_decode #(.IO_SPAN(IO_SPAN)) io_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
        .io_base(io_base), .io_hit(io_hit)
    );

    assert_bases_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_base[11:0] == 12'h000) && (ram_base[11:0] == 12'h000));
    assert_old_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && !page_we) |=> $stable(page_q));
endmodule

// File: tb/bank_xlate_tb_top.sv
module bank_xlate_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        place_we = 1'b0;
    logic [7:0]  place_wdata = '0;
    logic        page_we = 1'b0;
    logic [7:0]  page_wdata = '0;
    logic [23:0] phys_addr;
    logic        win_hit, io_hit;
    logic [15:0] io_base, ram_base;

    int checks = 0;
    int errors = 0;

    bank_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
        .place_we(place_we), .place_wdata(place_wdata),
        .page_we(page_we), .page_wdata(page_wdata),
        .phys_addr(phys_addr), .win_hit(win_hit), .io_hit(io_hit),
        .io_base(io_base), .ram_base(ram_base)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [23:0] exp_phys(input logic [15:0] a, input logic [7:0] pg);
        if (a >= 16'h8000 && a < 16'hC000)
            return 24'(a - 16'h8000) + (24'(pg) << 14) + 24'h010000;
        return 24'(a);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive on a falling edge, sample a quarter period later.
    task automatic look(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a;
        #(CLK_PERIOD/4);
    endtask

    task automatic wr_place(input logic [7:0] v);
        @(negedge clk); place_we = 1'b1; place_wdata = v;
        @(negedge clk); place_we = 1'b0;
    endtask

    task automatic wr_page(input logic [7:0] v);
        @(negedge clk); page_we = 1'b1; page_wdata = v;
        @(negedge clk); page_we = 1'b0;
    endtask

    task automatic t_reset;
        look(16'h8010);
        check("R1 io_base", 32'(io_base), 32'h1000);
        check("R1 ram_base", 32'(ram_base), 32'h0000);
        check("R1 page0", 32'(phys_addr), 32'(exp_phys(16'h8010, 8'h00)));
    endtask

    task automatic t_bases;
        wr_place(8'hA5);
        #(CLK_PERIOD/4);
        check("R2 io_base", 32'(io_base), 32'h5000);
        check("R3 ram_base", 32'(ram_base), 32'hA000);
        repeat (3) @(negedge clk);
        check("R4 hold", 32'({ram_base, io_base}), 32'hA0005000);
    endtask

    task automatic t_window;
        wr_page(8'h03);
        look(16'h7FFF); check("R5 below start", 32'(win_hit), 0);
        check("R7 pass", 32'(phys_addr), 32'h007FFF);
        look(16'h8000); check("R5 at start", 32'(win_hit), 1);
        check("R6 start", 32'(phys_addr), 32'(exp_phys(16'h8000, 8'h03)));
        look(16'hBFFF); check("R5 last", 32'(win_hit), 1);
        look(16'hC000); check("R5 at end", 32'(win_hit), 0);
        check("R7 pass end", 32'(phys_addr), 32'h00C000);
        look(16'h8123); check("R6 p3", 32'(phys_addr), 32'h01C123);
        wr_page(8'hFF);
        look(16'hBFFF); check("R6 pFF", 32'(phys_addr), 32'h40FFFF);
        look(16'h1234); check("R7 low", 32'(phys_addr), 32'h001234);
    endtask

    task automatic t_io;
        look(16'h5000); check("R8 base", 32'(io_hit), 1);
        look(16'h503F); check("R8 top", 32'(io_hit), 1);
        look(16'h5040); check("R8 past", 32'(io_hit), 0);
        look(16'h4FFF); check("R8 below", 32'(io_hit), 0);
        wr_place(8'h0F);
        look(16'hF03F); check("R8 high slot", 32'(io_hit), 1);
        look(16'hFFFF); check("R8 nowrap", 32'(io_hit), 0);
    endtask

    task automatic t_same_cycle;
        wr_page(8'h03);
        @(negedge clk);
        cpu_addr = 16'h8000; page_we = 1'b1; page_wdata = 8'h07;
        #(CLK_PERIOD/4);
        check("R9 old page", 32'(phys_addr), 32'h01C000);
        @(negedge clk); page_we = 1'b0;
        #(CLK_PERIOD/4);
        check("R9 new page", 32'(phys_addr), 32'h02C000);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bases();
        t_window();
        t_io();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule